// File: doc/BRIEF.md
# Way-Predicted Two-Way Instruction Cache

This block is a small two-way set-associative instruction cache. A per-set way predictor lets most hits return in one cycle. Each lookup trusts the predicted way first. A tag match there is a fast hit. A match found only in the other way is a slow hit, which costs one extra cycle. When neither way matches, the cache asks for the line through a simple fill port and installs it.

Each set keeps two predictor bits. One serves fetches marked as branch targets and the other serves sequential fetches. A requester marks every fetch with its kind. It presents a new fetch only while the cache shows ready. It then receives one whole line together with a flag that says how the fetch was served.

Top module: `wp_icache`

## Requirements
- R1: After reset `req_ready_o` is high, and `rsp_valid_o` and `fill_req_o` are low. Every line is invalid, so the first fetch to any address misses.
- R2: When the tag matches in the predicted way, the response comes in the cycle right after acceptance. It carries `rsp_fast_o` and the stored line, and `req_ready_o` stays high, so fast hits can run back to back.
- R3: When the tag matches only in the non-predicted way, `req_ready_o` drops for one cycle. The response comes two cycles after acceptance with `rsp_slow_o` set.
- R4: When the tag matches in neither way, `fill_req_o` rises in the cycle after acceptance with the line address. `fill_req_o` and the address are held until `fill_valid_i`, and `req_ready_o` stays low for that whole time.
- R5: The line on `fill_data_i` is written into the set's victim way. The response follows one cycle after the `fill_valid_i` cycle, with `rsp_miss_o` set and the filled line as data.
- R6: Each set has a sequential predictor bit, used when `req_branch_i`=0, and a branch-target predictor bit, used when `req_branch_i`=1. After a hit or a fill, only the bit of that access's kind is set to the way that served it.
- R7: Each set has a victim bit. After any hit or fill in a set, the way that was not used becomes the victim. Reset makes way 0 the victim.
- R8: Reset sets every predictor bit to way 0.
- R9: Every response carries exactly one of fast, slow or miss. A request presented while `req_ready_o` is low is ignored.
- R10: Address split with the default parameters: bits [3:0] are the byte offset and are ignored by the lookup, bits [8:4] select the set, and bits [31:9] form the tag. `fill_addr_o` has the offset bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request present |
| req_addr_i | input | ADDR_W | Fetch byte address |
| req_branch_i | input | 1 | 1 = branch-target fetch, 0 = sequential fetch |
| req_ready_o | output | 1 | A request is taken on this cycle's edge |
| rsp_valid_o | output | 1 | Response present (one cycle) |
| rsp_data_o | output | LINE_BYTES*8 | Returned line |
| rsp_fast_o | output | 1 | Served from the predicted way |
| rsp_slow_o | output | 1 | Served from the other way |
| rsp_miss_o | output | 1 | Served by a line fill |
| fill_req_o | output | 1 | Line fill wanted |
| fill_addr_o | output | ADDR_W | Line-aligned address of the wanted line |
| fill_valid_i | input | 1 | Fill line present |
| fill_data_i | input | LINE_BYTES*8 | Fill line |

## Verification
The bench places two lines in one set and then moves between the two fetch kinds. If the predictor bits were shared, a branch-target fetch right after a sequential slow hit would come back fast instead of slow. If the victim bit were updated wrongly, a third tag in the set would evict the line that had just been used, and the next fetch of it would miss when it should hit. A random phase holds requests asserted while the cache is busy. A design that took such a request would produce a response the reference model does not expect. The bench also varies fill delays, so a cache that drops `fill_req_o` early or replies before `fill_valid_i` fails the per-clock comparison.

// File: rtl/wp_icache_pkg.sv
package wp_icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOW = 2'd1,
    ST_FILL = 2'd2
  } ic_state_e;
endpackage

// File: rtl/wp_icache_way.sv
module wp_icache_way #(
  parameter int SETS   = 32,
  parameter int TAG_W  = 23,
  parameter int LINE_W = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] rd_idx_i,
  output logic                    rd_valid_o,
  output logic [TAG_W-1:0]        rd_tag_o,
  output logic [LINE_W-1:0]       rd_data_o,
  input  logic                    wr_en_i,
  input  logic [$clog2(SETS)-1:0] wr_idx_i,
  input  logic [TAG_W-1:0]        wr_tag_i,
  input  logic [LINE_W-1:0]       wr_data_i
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wp_icache_pred.sv
module wp_icache_pred #(
  parameter int SETS = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] rd_idx_i,
  output logic                    pred_seq_o,
  output logic                    pred_br_o,
  output logic                    victim_o,
  input  logic                    upd_en_i,
  input  logic [$clog2(SETS)-1:0] upd_idx_i,
  input  logic                    upd_branch_i,
  input  logic                    upd_way_i
);
  logic [SETS-1:0] seq_q, br_q, lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= '0;
      br_q  <= '0;
      lru_q <= '0;
    end else if (upd_en_i) begin
      if (upd_branch_i) br_q[upd_idx_i]  <= upd_way_i;
      else              seq_q[upd_idx_i] <= upd_way_i;
      lru_q[upd_idx_i] <= ~upd_way_i;
    end
  end

  assign pred_seq_o = seq_q[rd_idx_i];
  assign pred_br_o  = br_q[rd_idx_i];
  assign victim_o   = lru_q[rd_idx_i];
endmodule

// File: rtl/wp_icache.sv
module wp_icache
  import wp_icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic                    req_branch_i,
  output logic                    req_ready_o,
  output logic                    rsp_valid_o,
  output logic [LINE_BYTES*8-1:0] rsp_data_o,
  output logic                    rsp_fast_o,
  output logic                    rsp_slow_o,
  output logic                    rsp_miss_o,
  output logic                    fill_req_o,
  output logic [ADDR_W-1:0]       fill_addr_o,
  input  logic                    fill_valid_i,
  input  logic [LINE_BYTES*8-1:0] fill_data_i
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAYS   = 2;

  ic_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              br_q, way_q;

  logic              idle;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              look_br;

  logic              way_valid [WAYS];
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [LINE_W-1:0] way_data  [WAYS];
  logic [WAYS-1:0]   hit_w;
  logic [WAYS-1:0]   wr_en;

  logic pred_seq, pred_br, victim;
  logic pred_way, alt_way;
  logic accept, fast_hit, slow_hit, miss, fill_done;
  logic upd_en, upd_way;
  logic unused_off;

  assign unused_off = ^req_addr_i[OFF_W-1:0];

  assign idle     = (state_q == ST_IDLE);
  assign look_idx = idle ? req_addr_i[OFF_W +: IDX_W] : idx_q;
  assign look_tag = idle ? req_addr_i[ADDR_W-1 -: TAG_W] : tag_q;
  assign look_br  = idle ? req_branch_i : br_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wp_icache_way #(
      .SETS   (SETS),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
    ) i_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (look_idx),
      .rd_valid_o (way_valid[w]),
      .rd_tag_o   (way_tag[w]),
      .rd_data_o  (way_data[w]),
      .wr_en_i    (wr_en[w]),
      .wr_idx_i   (idx_q),
      .wr_tag_i   (tag_q),
      .wr_data_i  (fill_data_i)
    );
    assign hit_w[w] = way_valid[w] && (way_tag[w] == look_tag);
    assign wr_en[w] = fill_done && (victim == w[0]);
  end

  wp_icache_pred #(.SETS(SETS)) i_pred (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (look_idx),
    .pred_seq_o   (pred_seq),
    .pred_br_o    (pred_br),
    .victim_o     (victim),
    .upd_en_i     (upd_en),
    .upd_idx_i    (look_idx),
    .upd_branch_i (look_br),
    .upd_way_i    (upd_way)
  );

  assign pred_way  = look_br ? pred_br : pred_seq;
  assign alt_way   = ~pred_way;
  assign accept    = idle && req_valid_i;
  assign fast_hit  = accept && hit_w[pred_way];
  assign slow_hit  = accept && !hit_w[pred_way] && hit_w[alt_way];
  assign miss      = accept && (hit_w == '0);
  assign fill_done = (state_q == ST_FILL) && fill_valid_i;

  assign upd_en  = fast_hit || slow_hit || fill_done;
  assign upd_way = fill_done ? victim : (fast_hit ? pred_way : alt_way);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (slow_hit)  state_d = ST_SLOW;
        else if (miss) state_d = ST_FILL;
      end
      ST_SLOW: state_d = ST_IDLE;
      ST_FILL: if (fill_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tag_q   <= '0;
      br_q    <= 1'b0;
      way_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q <= look_idx;
        tag_q <= look_tag;
        br_q  <= req_branch_i;
        way_q <= alt_way;
      end
    end
  end

  // Response register: one cycle after a fast hit, slow-state cycle or fill.
  logic              rsp_valid_q, rsp_fast_q, rsp_slow_q, rsp_miss_q;
  logic [LINE_W-1:0] rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_fast_q  <= 1'b0;
      rsp_slow_q  <= 1'b0;
      rsp_miss_q  <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= fast_hit || (state_q == ST_SLOW) || fill_done;
      rsp_fast_q  <= fast_hit;
      rsp_slow_q  <= (state_q == ST_SLOW);
      rsp_miss_q  <= fill_done;
      if (fast_hit)                rsp_data_q <= way_data[pred_way];
      else if (state_q == ST_SLOW) rsp_data_q <= way_data[way_q];
      else if (fill_done)          rsp_data_q <= fill_data_i;
    end
  end

  assign req_ready_o = idle;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fast_o  = rsp_fast_q;
  assign rsp_slow_o  = rsp_slow_q;
  assign rsp_miss_o  = rsp_miss_q;
  assign rsp_data_o  = rsp_data_q;
  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_addr_o = {tag_q, idx_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/wp_icache_chk.sv
module wp_icache_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_fast_o,
  input logic              rsp_slow_o,
  input logic              rsp_miss_o,
  input logic [LINE_W-1:0] rsp_data_o,
  input logic              fill_req_o,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              fill_valid_i,
  input logic [LINE_W-1:0] fill_data_i
);
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_fast_o, rsp_slow_o, rsp_miss_o}) == 1)); // R9

  AST_FAST_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fast_o) |-> $past(req_valid_i && req_ready_o)); // R2

  AST_SLOW_ONE_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !fill_req_o) |=> (rsp_valid_o && rsp_slow_o && req_ready_o)); // R3

  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o) && !req_ready_o)); // R4

  AST_FILL_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_valid_i) |=> (rsp_valid_o && rsp_miss_o && rsp_data_o == $past(fill_data_i))); // R5

  AST_MISS_NEEDS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_miss_o) |-> $past(fill_req_o && fill_valid_i)); // R5
endmodule

bind wp_icache wp_icache_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_BYTES * 8)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_fast_o   (rsp_fast_o),
  .rsp_slow_o   (rsp_slow_o),
  .rsp_miss_o   (rsp_miss_o),
  .rsp_data_o   (rsp_data_o),
  .fill_req_o   (fill_req_o),
  .fill_addr_o  (fill_addr_o),
  .fill_valid_i (fill_valid_i),
  .fill_data_i  (fill_data_i)
);

// File: tb/test_wp_icache.sv
module test_wp_icache;
  localparam int CLK_PERIOD = 10;
  localparam int SETS       = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_br = 1'b0;
  logic         req_ready;
  logic         rsp_valid, rsp_fast, rsp_slow, rsp_miss;
  logic [127:0] rsp_data;
  logic         fill_req;
  logic [31:0]  fill_addr;
  logic         fill_valid = 1'b0;
  logic [127:0] fill_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_icache i_wp_icache (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_addr_i (req_addr), .req_branch_i (req_br),
    .req_ready_o (req_ready),
    .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data),
    .rsp_fast_o (rsp_fast), .rsp_slow_o (rsp_slow), .rsp_miss_o (rsp_miss),
    .fill_req_o (fill_req), .fill_addr_o (fill_addr),
    .fill_valid_i (fill_valid), .fill_data_i (fill_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] line_of(input logic [31:0] a);
    logic [31:0] l = {a[31:4], 4'h0};
    return {l ^ 32'h1234_5678, ~l, l * 32'd3, l[15:0], 16'hbeef};
  endfunction

  function automatic logic [31:0] mk(input int tg, input int idx, input int off);
    return {tg[22:0], idx[4:0], off[3:0]};
  endfunction

  // Behavioural reference model
  bit           m_v   [2][SETS];
  int unsigned  m_tag [2][SETS];
  logic [127:0] m_dat [2][SETS];
  int m_ps [SETS];
  int m_pb [SETS];
  int m_lru[SETS];
  int m_state;       // 0 idle, 1 slow, 2 fill
  int p_idx, p_tag, p_br, p_way;
  bit e_rv;
  int e_kind;        // 0 fast, 1 slow, 2 miss
  logic [127:0] e_data;
  int t_idx, t_tag, t_pw, t_w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        m_v[0][s] = 0; m_v[1][s] = 0;
        m_ps[s] = 0; m_pb[s] = 0; m_lru[s] = 0;
      end
      m_state = 0; e_rv = 0; e_kind = 0; e_data = '0;
    end else begin
      e_rv = 0;
      case (m_state)
        0: if (req_valid) begin
          t_idx = int'(req_addr[8:4]);
          t_tag = int'(req_addr[31:9]);
          t_pw  = req_br ? m_pb[t_idx] : m_ps[t_idx];
          if (m_v[t_pw][t_idx] && m_tag[t_pw][t_idx] == t_tag) begin
            e_rv = 1; e_kind = 0; e_data = m_dat[t_pw][t_idx];
            t_w = t_pw;
          end else if (m_v[1-t_pw][t_idx] && m_tag[1-t_pw][t_idx] == t_tag) begin
            m_state = 1; p_way = 1 - t_pw; p_idx = t_idx;
            t_w = 1 - t_pw;
          end else begin
            m_state = 2; p_idx = t_idx; p_tag = t_tag; p_br = int'(req_br);
            t_w = -1;
          end
          if (t_w >= 0) begin
            if (req_br) m_pb[t_idx] = t_w; else m_ps[t_idx] = t_w;
            m_lru[t_idx] = 1 - t_w;
          end
        end
        1: begin
          e_rv = 1; e_kind = 1; e_data = m_dat[p_way][p_idx]; m_state = 0;
        end
        2: if (fill_valid) begin
          t_w = m_lru[p_idx];
          m_v[t_w][p_idx] = 1; m_tag[t_w][p_idx] = p_tag; m_dat[t_w][p_idx] = fill_data;
          if (p_br != 0) m_pb[p_idx] = t_w; else m_ps[p_idx] = t_w;
          m_lru[p_idx] = 1 - t_w;
          e_rv = 1; e_kind = 2; e_data = fill_data; m_state = 0;
        end
        default: m_state = 0;
      endcase
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == (m_state == 0), "R3/R4", "req_ready", 128'(req_ready), 128'(m_state == 0));
      check(fill_req == (m_state == 2), "R4", "fill_req", 128'(fill_req), 128'(m_state == 2));
      if (m_state == 2)
        check(fill_addr == {p_tag[22:0], p_idx[4:0], 4'h0}, "R10", "fill_addr",
              128'(fill_addr), 128'({p_tag[22:0], p_idx[4:0], 4'h0}));
      check(rsp_valid == e_rv, "R9", "rsp_valid", 128'(rsp_valid), 128'(e_rv));
      if (e_rv && rsp_valid) begin
        check(rsp_fast == (e_kind == 0), "R2", "rsp_fast", 128'(rsp_fast), 128'(e_kind == 0));
        check(rsp_slow == (e_kind == 1), "R3", "rsp_slow", 128'(rsp_slow), 128'(e_kind == 1));
        check(rsp_miss == (e_kind == 2), "R5", "rsp_miss", 128'(rsp_miss), 128'(e_kind == 2));
        check(rsp_data == e_data, "R5", "rsp_data", rsp_data, e_data);
      end
    end
  end

  // Fill responder with varying delay
  int fcnt = 0;
  always @(negedge clk) begin
    fill_valid = 1'b0;
    if (rst_n && fill_req) begin
      if (fcnt == 0) begin
        fill_valid = 1'b1;
        fill_data  = line_of(fill_addr);
        fcnt = $urandom_range(0, 3);
      end else begin
        fcnt--;
      end
    end
  end

  task automatic access(input logic [31:0] a, input bit br, input int exp_kind, input string rq);
    int lat;
    int kind;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_br = br;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    kind = rsp_fast ? 0 : rsp_slow ? 1 : rsp_miss ? 2 : 3;
    check(kind == exp_kind, rq, "kind", 128'(kind), 128'(exp_kind));
    check(rsp_data == line_of(a), rq, "data", rsp_data, line_of(a));
    if (exp_kind == 0) check(lat == 1, rq, "fast latency", 128'(lat), 128'(1));
    if (exp_kind == 1) check(lat == 2, rq, "slow latency", 128'(lat), 128'(2));
    if (exp_kind == 2) check(lat >= 2 && lat < 50, rq, "miss latency", 128'(lat), 128'(2));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready in reset", 128'(req_ready), 128'(1));
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 128'(rsp_valid), 128'(0));
    check(fill_req == 1'b0, "R1", "fill_req in reset", 128'(fill_req), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !fill_req, "R1", "after reset", 128'(req_ready), 128'(1));

    access(mk(1, 3, 0), 0, 2, "R1");      // cold miss, way0
    access(mk(1, 3, 8), 0, 0, "R10");     // offset ignored, fast
    access(mk(2, 3, 4), 0, 2, "R5");      // fill victim way1
    access(mk(1, 3, 0), 0, 1, "R6");      // seq predicts way1 -> slow
    access(mk(1, 3, 12), 1, 0, "R8");     // branch bit still way0 -> fast
    access(mk(2, 3, 0), 1, 1, "R3");      // branch predicts way0 -> slow
    access(mk(2, 3, 0), 0, 1, "R6");      // seq untouched by branch update -> slow
    access(mk(3, 3, 0), 0, 2, "R7");      // victim way0 evicts tag 1
    access(mk(2, 3, 0), 0, 1, "R7");      // tag 2 survives in way1
    access(mk(1, 3, 0), 0, 2, "R7");      // tag 1 was evicted
    access(mk(5, 5, 0), 1, 2, "R10");     // other set cold
    access(mk(5, 5, 4), 0, 0, "R8");      // seq default way0 -> fast
    access(mk(1, 4, 0), 0, 2, "R10");     // same tag, other index -> miss
    access(mk(1, 4, 0), 0, 0, "R2");
    access(mk(1, 4, 4), 0, 0, "R2");

    // Random phase: requests may stay asserted while not ready (R9)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 3) != 0);
      req_addr  = mk($urandom_range(1, 3), $urandom_range(0, 2), $urandom_range(0, 15));
      req_br    = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule